// File: doc/BRIEF.md
# Multi-Source Reset Merger with Strap Capture

This block folds four independent reset causes into a single active-low core reset and a matching active-low reset output for the board. The four causes are a main reset pin, a PCI bus reset, a one-cycle watchdog expiry pulse and a software request. The two pin resets take effect the instant they go low. Their release is retimed into the core clock through a short synchronizer chain. The watchdog and software causes are synchronous and hold the core in reset for a fixed minimum window.

When the main reset is released, the block latches a bank of configuration straps and a strap that decides how the board reset output behaves. The PCI width strap is handled separately: it is taken only when the PCI reset is released, by sampling the active-low 64-bit request line. A one-word control port carries the enable for the board reset output and the software reset trigger.

The block also keeps two sticky records, both cleared only by the power-on reset. The first notes which cause started the most recent reset. The second is a flag that is raised when the PCI reset is released before the main reset.

Top module: `rst_merge_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst_n` and `ext_rst_out_n` are low, taking effect without waiting for a clock edge.
- R2: After `ext_rst_n` rises, with no other cause active, `core_rst_n` rises at the second rising clock edge.
- R3: The PCI reset `pci_rst_n` asserts and releases the core reset in the same way as the main pin (immediate assertion, release at the second edge).
- R4: A `wdt_expire` pulse, or a control write with `ctl_wdata[0]`=1, drives `core_rst_n` low from the next edge for exactly 16 cycles. A new trigger inside the window restarts the full count.
- R5: At the edge after the synchronized release of the main reset, `strap_q` loads `strap_in` and the internal out-strap loads `rst_out_strap`. Both hold their values at all other times.
- R6: `bus64_q` loads the inverse of `req64_n` only at the edge after the synchronized release of the PCI reset. A main-reset release does not change it.
- R7: A control write sets the output-enable from `ctl_wdata[22]`. The power-on reset `por_n` clears it to 0.
- R8: `ext_rst_out_n` equals `core_rst_n` when the enable is 1. When the enable is 0, it follows `core_rst_n` only if the captured out-strap is 1, and otherwise it stays low.
- R9: `cause_q` is written with the set of causes whose assertion began in a cycle. Bit 0 is main, bit 1 is PCI, bit 2 is watchdog and bit 3 is software. The value is retained until the next such event, and only `por_n` clears it.
- R10: `order_err` becomes 1 and stays 1 (until `por_n`) if the PCI reset completes its synchronized release while the main reset is still held. Simultaneous release does not flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| ext_rst_n | input | 1 | Main reset pin, active low, asynchronous |
| pci_rst_n | input | 1 | PCI bus reset, active low, asynchronous |
| wdt_expire | input | 1 | One-cycle watchdog expiry pulse |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; bit 22 output enable, bit 0 software reset trigger |
| strap_in | input | 8 | Configuration strap pins |
| rst_out_strap | input | 1 | Strap selecting board reset output behaviour |
| req64_n | input | 1 | 64-bit request line, sensed at PCI reset release |
| core_rst_n | output | 1 | Merged internal reset, active low |
| ext_rst_out_n | output | 1 | Board reset output, active low |
| strap_q | output | 8 | Captured configuration straps |
| bus64_q | output | 1 | Captured PCI width strap |
| cause_q | output | 4 | Sticky record of the last reset cause |
| order_err | output | 1 | Sticky flag: PCI reset released before main reset |

## Verification
The bench builds the block with an 8-bit strap bank, a 16-cycle stretch and two synchronizer stages. With these values the full stretch window, a restart inside it, and both synchronizer releases can all be observed edge by edge within a short run. The bench holds the straps and the request line at values that differ between the two release kinds, so that a capture on the wrong edge shows up at the outputs. It also drives release orders where the PCI reset goes first, goes together with the main reset, and goes alone, so that the ordering flag is exercised in each case.

// File: rtl/rst_merge_pkg.sv
package rst_merge_pkg;
   localparam int NUM_CAUSE = 4;
   localparam int CAUSE_MAIN = 0;
   localparam int CAUSE_PCI  = 1;
   localparam int CAUSE_WDT  = 2;
   localparam int CAUSE_SW   = 3;

   typedef struct packed {
      logic sw;
      logic wdt;
      logic pci;
      logic main;
   } cause_t;
endpackage

// File: rtl/rst_sync_cell.sv
module rst_sync_cell #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic sync_n
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rst_sync_cell: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign sync_n = chain_q[STAGES-1];

   assert_async_hold_R1: assert property (@(posedge clk) !arst_n |-> !sync_n);
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic trig,
   output logic active
);
   localparam int CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LOAD = CW'(LEN);

   generate
      if (LEN < 1) begin : g_bad
         $error("rst_stretch: LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              cnt_q <= '0;
      else if (trig)           cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);

   assert_reload_R4: assert property (@(posedge clk) disable iff (!por_n)
      trig |=> cnt_q == LOAD);
   assert_countdown_R4: assert property (@(posedge clk) disable iff (!por_n)
      (active && !trig) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         cap,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad
         $error("strap_latch: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)   q <= '0;
      else if (cap) q <= d;
   end

   assert_capture_R5: assert property (@(posedge clk) disable iff (!por_n)
      cap |=> q == $past(d));
   assert_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
      !cap |=> $stable(q));
endmodule

// File: rtl/rst_merge_ctrl.sv
module rst_merge_ctrl #(
   parameter int STRAP_W     = 8,
   parameter int STRETCH_CYC = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CTL_W       = 32,
   parameter int EN_BIT      = 22,
   parameter int SW_BIT      = 0
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               ext_rst_n,
   input  logic               pci_rst_n,
   input  logic               wdt_expire,
   input  logic               ctl_we,
   input  logic [CTL_W-1:0]   ctl_wdata,
   input  logic [STRAP_W-1:0] strap_in,
   input  logic               rst_out_strap,
   input  logic               req64_n,
   output logic               core_rst_n,
   output logic               ext_rst_out_n,
   output logic [STRAP_W-1:0] strap_q,
   output logic               bus64_q,
   output logic [3:0]         cause_q,
   output logic               order_err
);
   import rst_merge_pkg::*;

   localparam int NPIN = 2;
   localparam int IDX_MAIN = 0;
   localparam int IDX_PCI  = 1;

   generate
      if (EN_BIT >= CTL_W || SW_BIT >= CTL_W || EN_BIT == SW_BIT) begin : g_bad
         $error("rst_merge_ctrl: control bit positions out of range");
      end
   endgenerate

   // pin resets: immediate assert, retimed release
   logic [NPIN-1:0] pin_arst_n;
   logic [NPIN-1:0] pin_sync_n;
   assign pin_arst_n[IDX_MAIN] = ext_rst_n & por_n;
   assign pin_arst_n[IDX_PCI]  = pci_rst_n & por_n;

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      rst_sync_cell #(.STAGES(SYNC_STAGES)) i_sync (
         .clk    (clk),
         .arst_n (pin_arst_n[i]),
         .sync_n (pin_sync_n[i])
      );
   end

   // edge tracking of synchronized pin resets
   logic [NPIN-1:0] act_prev_q;
   logic [NPIN-1:0] pin_act, pin_fall, pin_rel;
   assign pin_act  = ~pin_sync_n;
   assign pin_fall = pin_act & ~act_prev_q;
   assign pin_rel  = pin_sync_n & act_prev_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) act_prev_q <= '1;
      else        act_prev_q <= pin_act;
   end

   // synchronous causes
   logic sw_pulse, stretch_trig, stretch_act;
   assign sw_pulse     = ctl_we & ctl_wdata[SW_BIT];
   assign stretch_trig = sw_pulse | wdt_expire;

   rst_stretch #(.LEN(STRETCH_CYC)) i_stretch (
      .clk    (clk),
      .por_n  (por_n),
      .trig   (stretch_trig),
      .active (stretch_act)
   );

   assign core_rst_n = por_n & pin_sync_n[IDX_MAIN] & pin_sync_n[IDX_PCI] & ~stretch_act;

   // strap capture
   logic [STRAP_W:0] main_cap_q;
   strap_latch #(.W(STRAP_W + 1)) i_main_straps (
      .clk   (clk),
      .por_n (por_n),
      .cap   (pin_rel[IDX_MAIN]),
      .d     ({rst_out_strap, strap_in}),
      .q     (main_cap_q)
   );
   assign strap_q = main_cap_q[STRAP_W-1:0];

   logic out_strap_q;
   assign out_strap_q = main_cap_q[STRAP_W];

   logic [0:0] b64_q;
   strap_latch #(.W(1)) i_pci_strap (
      .clk   (clk),
      .por_n (por_n),
      .cap   (pin_rel[IDX_PCI]),
      .d     (~req64_n),
      .q     (b64_q)
   );
   assign bus64_q = b64_q[0];

   // control enable bit
   logic out_en_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      out_en_q <= 1'b0;
      else if (ctl_we) out_en_q <= ctl_wdata[EN_BIT];
   end

   assign ext_rst_out_n = core_rst_n & (out_en_q | out_strap_q);

   // sticky cause record
   cause_t cause_ev, cause_r;
   always_comb begin
      cause_ev      = '0;
      cause_ev.main = pin_fall[IDX_MAIN];
      cause_ev.pci  = pin_fall[IDX_PCI];
      cause_ev.wdt  = wdt_expire;
      cause_ev.sw   = sw_pulse;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              cause_r <= '0;
      else if (cause_ev != '0) cause_r <= cause_ev;
   end
   assign cause_q = cause_r;

   // release ordering check
   logic err_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                         err_q <= 1'b0;
      else if (pin_rel[IDX_PCI] && !pin_sync_n[IDX_MAIN]) err_q <= 1'b1;
   end
   assign order_err = err_q;

   logic wdata_unused;
   assign wdata_unused = ^ctl_wdata;

   assert_main_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
      !ext_rst_n |-> (!core_rst_n && !ext_rst_out_n));
   assert_pci_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
      !pci_rst_n |-> !core_rst_n);
   assert_trig_holds_R4: assert property (@(posedge clk) disable iff (!por_n)
      stretch_trig |=> !core_rst_n);
   assert_pci_only_R6: assert property (@(posedge clk) disable iff (!por_n)
      !pin_rel[IDX_PCI] |=> $stable(bus64_q));
   assert_out_gate_R8: assert property (@(posedge clk) disable iff (!por_n)
      !core_rst_n |-> !ext_rst_out_n);
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
      order_err |=> order_err);
endmodule

// File: tb/test_rst_merge_ctrl.sv
module test_rst_merge_ctrl;
   localparam int SW = 8;
   localparam int STR = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic por_n, ext_rst_n, pci_rst_n, wdt_expire, ctl_we, rst_out_strap, req64_n;
   logic [31:0] ctl_wdata;
   logic [SW-1:0] strap_in;
   logic core_rst_n, ext_rst_out_n, bus64_q, order_err;
   logic [SW-1:0] strap_q;
   logic [3:0] cause_q;

   rst_merge_ctrl #(.STRAP_W(SW), .STRETCH_CYC(STR)) i_rst_merge_ctrl (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pci_rst_n(pci_rst_n),
      .wdt_expire(wdt_expire), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .strap_in(strap_in), .rst_out_strap(rst_out_strap), .req64_n(req64_n),
      .core_rst_n(core_rst_n), .ext_rst_out_n(ext_rst_out_n), .strap_q(strap_q),
      .bus64_q(bus64_q), .cause_q(cause_q), .order_err(order_err));

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model state
   bit m_e1, m_e2, m_p1, m_p2, m_eprev, m_pprev, m_outs, m_b64, m_viol, m_en;
   int m_cnt;
   logic [SW-1:0] m_straps;
   logic [3:0] m_cause;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic apply_async();
      if (!por_n) begin
         m_e1 = 0; m_e2 = 0; m_p1 = 0; m_p2 = 0; m_eprev = 1; m_pprev = 1;
         m_outs = 0; m_b64 = 0; m_viol = 0; m_en = 0; m_cnt = 0;
         m_straps = '0; m_cause = '0;
      end
      if (!ext_rst_n) begin m_e1 = 0; m_e2 = 0; end
      if (!pci_rst_n) begin m_p1 = 0; m_p2 = 0; end
   endtask

   task automatic model_step();
      bit eo, po, epo, ppo, swp, trig, erel, prel, efall, pfall;
      logic [3:0] ev;
      apply_async();
      if (!por_n) return;
      eo = m_e2; po = m_p2; epo = m_eprev; ppo = m_pprev;
      swp = ctl_we & ctl_wdata[0];
      trig = swp | wdt_expire;
      erel = eo & epo;  prel = po & ppo;
      efall = !eo & !epo; pfall = !po & !ppo;
      if (ext_rst_n) begin m_e2 = m_e1; m_e1 = 1; end
      if (pci_rst_n) begin m_p2 = m_p1; m_p1 = 1; end
      m_eprev = !eo; m_pprev = !po;
      if (trig) m_cnt = STR; else if (m_cnt > 0) m_cnt--;
      if (erel) begin m_straps = strap_in; m_outs = rst_out_strap; end
      if (prel) m_b64 = !req64_n;
      if (prel && !eo) m_viol = 1;
      ev = {swp, wdt_expire, pfall, efall};
      if (ev != 0) m_cause = ev;
      if (ctl_we) m_en = ctl_wdata[22];
   endtask

   function automatic bit exp_core();
      return por_n & m_e2 & m_p2 & (m_cnt == 0);
   endfunction

   task automatic compare();
      bit ec;
      ec = exp_core();
      chk(core_rst_n == ec, "R2 core_rst_n", core_rst_n, ec);
      chk(ext_rst_out_n == (ec & (m_en | m_outs)), "R8 ext_rst_out_n", ext_rst_out_n, ec & (m_en | m_outs));
      chk(strap_q == m_straps, "R5 strap_q", strap_q, m_straps);
      chk(bus64_q == m_b64, "R6 bus64_q", bus64_q, m_b64);
      chk(cause_q == m_cause, "R9 cause_q", cause_q, m_cause);
      chk(order_err == m_viol, "R10 order_err", order_err, m_viol);
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         model_step();
         compare();
      end
   endtask

   task automatic write_ctl(input logic [31:0] v);
      @(negedge clk); ctl_we = 1; ctl_wdata = v;
      cyc(1);
      @(negedge clk); ctl_we = 0; ctl_wdata = '0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int lowcnt;
      por_n = 0; ext_rst_n = 0; pci_rst_n = 0; wdt_expire = 0; ctl_we = 0;
      ctl_wdata = '0; strap_in = 8'hA5; rst_out_strap = 1; req64_n = 0;
      apply_async();
      cyc(3);
      chk(core_rst_n == 0 && ext_rst_out_n == 0 && cause_q == 0 && strap_q == 0,
          "R7 reset state", {core_rst_n, ext_rst_out_n, cause_q}, 0);

      // power up: both pins released together
      @(negedge clk); por_n = 1;
      cyc(2);
      @(negedge clk); ext_rst_n = 1; pci_rst_n = 1;
      cyc(1);
      chk(core_rst_n == 0, "R2 still held after one edge", core_rst_n, 0);
      cyc(1);
      chk(core_rst_n == 1, "R2 released at second edge", core_rst_n, 1);
      cyc(2);
      chk(strap_q == 8'hA5 && bus64_q == 1, "R5 R6 power-up capture", {strap_q, bus64_q}, {8'hA5, 1'b1});
      chk(order_err == 0, "R10 simultaneous release no flag", order_err, 0);

      // main reset mid-operation
      @(negedge clk); ext_rst_n = 0; req64_n = 1; #1;
      chk(core_rst_n == 0 && ext_rst_out_n == 0, "R1 immediate assert", {core_rst_n, ext_rst_out_n}, 0);
      cyc(3);
      chk(cause_q == 4'b0001, "R9 main cause", cause_q, 1);
      @(negedge clk); strap_in = 8'h3C;
      cyc(1);
      @(negedge clk); ext_rst_n = 1;
      cyc(5);
      chk(strap_q == 8'h3C, "R5 recapture on main release", strap_q, 8'h3C);
      chk(bus64_q == 1, "R6 main release leaves bus64", bus64_q, 1);

      // PCI alone
      @(negedge clk); pci_rst_n = 0; strap_in = 8'hFF; #1;
      chk(core_rst_n == 0, "R3 PCI immediate assert", core_rst_n, 0);
      cyc(3);
      @(negedge clk); pci_rst_n = 1;
      cyc(1);
      chk(core_rst_n == 0, "R3 PCI still held", core_rst_n, 0);
      cyc(4);
      chk(bus64_q == 0 && strap_q == 8'h3C, "R6 PCI capture only", {strap_q, bus64_q}, {8'h3C, 1'b0});
      chk(cause_q == 4'b0010, "R9 PCI cause", cause_q, 2);
      chk(order_err == 0, "R10 PCI alone no flag", order_err, 0);

      // watchdog stretch
      @(negedge clk); wdt_expire = 1;
      cyc(1);
      @(negedge clk); wdt_expire = 0;
      lowcnt = 1;
      for (int i = 0; i < 30; i++) begin
         cyc(1);
         if (!core_rst_n) lowcnt++;
      end
      chk(lowcnt == STR, "R4 watchdog stretch length", lowcnt, STR);
      chk(cause_q == 4'b0100, "R9 watchdog cause", cause_q, 4);

      // software trigger and restart inside window
      write_ctl(32'h1);
      cyc(8);
      write_ctl(32'h1);
      lowcnt = 1;
      for (int i = 0; i < 30; i++) begin
         cyc(1);
         if (!core_rst_n) lowcnt++;
      end
      chk(lowcnt == STR, "R4 restart full count", lowcnt, STR);
      chk(cause_q == 4'b1000, "R9 software cause", cause_q, 8);

      // out strap 0 keeps board reset low until enabled
      @(negedge clk); rst_out_strap = 0; ext_rst_n = 0;
      cyc(3);
      @(negedge clk); ext_rst_n = 1;
      cyc(5);
      chk(core_rst_n == 1 && ext_rst_out_n == 0, "R8 strap0 holds output", ext_rst_out_n, 0);
      write_ctl(32'h0040_0000);
      cyc(1);
      chk(ext_rst_out_n == 1, "R7 enable bit 22 releases output", ext_rst_out_n, 1);
      write_ctl(32'h0040_0001);
      cyc(1);
      chk(ext_rst_out_n == 0, "R8 output follows core", ext_rst_out_n, 0);
      cyc(20);

      // ordering violation: PCI released first
      @(negedge clk); ext_rst_n = 0; pci_rst_n = 0;
      cyc(3);
      @(negedge clk); pci_rst_n = 1;
      cyc(4);
      chk(order_err == 1, "R10 flag on early PCI release", order_err, 1);
      @(negedge clk); ext_rst_n = 1;
      cyc(5);
      chk(order_err == 1, "R10 flag sticky", order_err, 1);

      // power-on clears
      @(negedge clk); por_n = 0; #1;
      apply_async();
      chk(order_err == 0 && cause_q == 0 && ext_rst_out_n == 0, "R7 por clears",
          {order_err, cause_q, ext_rst_out_n}, 0);
      cyc(2);
      @(negedge clk); por_n = 1;
      cyc(6);
      chk(ext_rst_out_n == 0, "R7 enable cleared by por", ext_rst_out_n, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule